// File: doc/BRIEF.md
# Programmable-Polarity Interrupt Aggregator

This block collects event conditions from four functional groups of a line-termination device and folds them into a single interrupt pin. The groups are a global group, a line-interface group, a framer group that owns several status registers, and a data-link group. Every group holds its conditions in sticky status registers, `W` bits wide. A one-cycle event pulse sets a bit, and the bit stays set until the host reads the register that holds it. Each status bit has its own enable bit. Each group also has a single group-level enable. A bit raises the interrupt only when both of these enables are set.

The pin is driven from a registered "interrupt active" flag. Two configuration bits shape the pin. One selects the active level. The other selects whether the idle state is driven or left to float through an output-enable signal. This lets the pin serve a point-to-point link at either polarity, or a shared line in wired-OR or wired-AND style.

Status register indices are fixed: 0 is global, 1 is line interface, 2 to `NFRM+1` are the framer registers, and `NFRM+2` is the data link. Reads use a one-cycle strobe and an address. The read data is the register content before the clear takes effect.

Top module: `irqagg_top`

## Requirements
- R1: An event pulse on `evt_i` bit `r*W+b` in a cycle sets status bit `b` of register `r` at that clock edge. The bit stays set in later cycles until its register is read.
- R2: A cycle with `rd_stb_i` high and `rd_addr_i` equal to `r` clears register `r` at that edge and leaves every other register unchanged. In that same cycle, `rd_data_o` shows the content of register `r` from before the clear. Without a strobe, `rd_data_o` still shows the register selected by `rd_addr_i`.
- R3: If an event on a bit arrives in the same cycle as a read that clears its register, that bit is set after the edge.
- R4: A status bit counts as pending only when its own `bit_en_i` bit is 1 and the `grp_en_i` bit of its group is 1. The group bits are: bit 0 for register 0, bit 1 for register 1, bit 2 for registers 2 to `NFRM+1`, and bit 3 for register `NFRM+2`.
- R5: The interrupt-active state is a register that takes the pending state at each clock edge. It becomes active one edge after a pending bit appears, and it becomes idle one edge after the clearing read.
- R6: Pin coding uses `pin_cfg_i[0]` to make the idle state float and `pin_cfg_i[1]` to make the pin active-low. The four codes behave as follows:
  - 00: high when active, low when idle, always driven.
  - 01: high when active, not driven (`irq_oe_o`=0) when idle.
  - 10: low when active, high when idle, always driven.
  - 11: low when active, not driven when idle.
  - When not driven, `irq_o` carries the idle level, which is active XOR `pin_cfg_i[1]`.
- R7: While `rst_n` is low, all status bits are 0 and the interrupt-active state is idle. With code 00, this gives `irq_o`=0 and `irq_oe_o`=1.
- R8: A read strobe with an address of `NFRM+3` or above clears nothing.
- R9: Clearing an enable (either kind) masks a status bit but does not erase it. Setting the enable again makes the bit pending again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | (NFRM+3)*W | One-cycle event pulses, bit r*W+b for register r bit b |
| bit_en_i | input | (NFRM+3)*W | Per-bit enables, same layout as evt_i |
| grp_en_i | input | 4 | Group enables: global, line, framer, data link |
| pin_cfg_i | input | 2 | [0] float when idle, [1] active-low |
| rd_stb_i | input | 1 | Status read strobe (clears the addressed register) |
| rd_addr_i | input | $clog2(NFRM+3) | Status register index |
| rd_data_o | output | W | Addressed status register, pre-clear |
| irq_o | output | 1 | Interrupt pin level |
| irq_oe_o | output | 1 | Interrupt pin output enable |

## Verification
The two functions that can fall in the same cycle are the setting of a status bit by an event and the clearing of that register by a host read. The bench provokes this with a directed case: a new event on one bit arrives together with a read of its register, while an older bit in that register is already set. The random phase also injects many such collisions with reads at random addresses. The result is judged through `rd_data_o` on the following cycle and through the pin level: the new bit must survive and keep the interrupt active, and the older bit must be gone.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

  typedef enum logic [1:0] {
    GRP_GLOBAL = 2'd0,
    GRP_LINE   = 2'd1,
    GRP_FRAMER = 2'd2,
    GRP_LINK   = 2'd3
  } grp_e;

  localparam int unsigned NGRP = 4;

  typedef struct packed {
    logic lvl;
    logic oe;
  } pin_t;

  // Group owning status register idx out of nreg registers.
  function automatic grp_e grp_of(int unsigned idx, int unsigned nreg);
    if (idx == 0)             return GRP_GLOBAL;
    else if (idx == 1)        return GRP_LINE;
    else if (idx == nreg - 1) return GRP_LINK;
    else                      return GRP_FRAMER;
  endfunction

  // cfg[0]: float when idle, cfg[1]: active-low.
  function automatic pin_t pin_drive(logic [1:0] cfg, logic act);
    pin_t p;
    p.oe  = act | ~cfg[0];
    p.lvl = act ^ cfg[1];
    return p;
  endfunction

endpackage

// File: rtl/irqagg_status.sv
module irqagg_status #(
  parameter int unsigned NREG = 11,
  parameter int unsigned W    = 8,
  parameter int unsigned AW   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NREG*W-1:0] evt_i,
  input  logic              rd_stb_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [NREG*W-1:0] sts_o,
  output logic [NREG-1:0]   clr_sel_o,
  output logic [W-1:0]      rd_data_o
);

  logic [W-1:0] q [NREG];

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [W-1:0] nxt;
    assign clr_sel_o[r] = rd_stb_i && (rd_addr_i == AW'(r));
    // set wins over clear on the same bit
    assign nxt = (q[r] & {W{~clr_sel_o[r]}}) | evt_i[r*W +: W];
    always_ff @(posedge clk) begin
      if (!rst_n) q[r] <= '0;
      else        q[r] <= nxt;
    end
    assign sts_o[r*W +: W] = q[r];
  end

  always_comb begin
    rd_data_o = '0;
    for (int r = 0; r < NREG; r++) begin
      if (rd_addr_i == AW'(r)) rd_data_o = q[r];
    end
  end

endmodule

// File: rtl/irqagg_gate.sv
module irqagg_gate
  import irqagg_pkg::*;
#(
  parameter int unsigned NREG = 11,
  parameter int unsigned W    = 8
) (
  input  logic [NREG*W-1:0] sts_i,
  input  logic [NREG*W-1:0] bit_en_i,
  input  logic [NGRP-1:0]   grp_en_i,
  output logic [NGRP-1:0]   grp_pend_o,
  output logic              pend_o
);

  logic [NREG-1:0] reg_pend;

  for (genvar r = 0; r < NREG; r++) begin : g_mask
    localparam grp_e G = grp_of(r, NREG);
    logic [W-1:0] masked;
    assign masked      = sts_i[r*W +: W] & bit_en_i[r*W +: W] & {W{grp_en_i[G]}};
    assign reg_pend[r] = |masked;
  end

  always_comb begin
    grp_pend_o = '0;
    for (int r = 0; r < NREG; r++) begin
      grp_pend_o[grp_of(r, NREG)] = grp_pend_o[grp_of(r, NREG)] | reg_pend[r];
    end
  end

  assign pend_o = |grp_pend_o;

endmodule

// File: rtl/irqagg_pin.sv
module irqagg_pin
  import irqagg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pend_i,
  input  logic [1:0] cfg_i,
  output logic       act_o,
  output logic       irq_o,
  output logic       irq_oe_o
);

  pin_t drv;

  always_ff @(posedge clk) begin
    if (!rst_n) act_o <= 1'b0;
    else        act_o <= pend_i;
  end

  assign drv      = pin_drive(cfg_i, act_o);
  assign irq_o    = drv.lvl;
  assign irq_oe_o = drv.oe;

endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
  import irqagg_pkg::*;
#(
  parameter int unsigned W    = 8,
  parameter int unsigned NFRM = 8,
  localparam int unsigned NREG = NFRM + 3,
  localparam int unsigned AW   = $clog2(NREG),
  localparam int unsigned NB   = NREG * W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] evt_i,
  input  logic [NB-1:0] bit_en_i,
  input  logic [3:0]    grp_en_i,
  input  logic [1:0]    pin_cfg_i,
  input  logic          rd_stb_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [W-1:0]  rd_data_o,
  output logic          irq_o,
  output logic          irq_oe_o
);

  logic [NB-1:0]   sts;
  logic [NREG-1:0] clr_sel;
  logic [NGRP-1:0] grp_pend;
  logic            pend;
  logic            act;

  irqagg_status #(.NREG(NREG), .W(W), .AW(AW)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt_i),
    .rd_stb_i  (rd_stb_i),
    .rd_addr_i (rd_addr_i),
    .sts_o     (sts),
    .clr_sel_o (clr_sel),
    .rd_data_o (rd_data_o)
  );

  irqagg_gate #(.NREG(NREG), .W(W)) u_gate (
    .sts_i      (sts),
    .bit_en_i   (bit_en_i),
    .grp_en_i   (grp_en_i),
    .grp_pend_o (grp_pend),
    .pend_o     (pend)
  );

  irqagg_pin u_pin (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend_i   (pend),
    .cfg_i    (pin_cfg_i),
    .act_o    (act),
    .irq_o    (irq_o),
    .irq_oe_o (irq_oe_o)
  );

endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk #(
  parameter int unsigned NREG = 11,
  parameter int unsigned W    = 8,
  parameter int unsigned AW   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NREG*W-1:0] evt,
  input logic [NREG*W-1:0] sts,
  input logic [NREG-1:0]   clr_sel,
  input logic              rd_stb,
  input logic [AW-1:0]     rd_addr,
  input logic              pend,
  input logic              act,
  input logic [1:0]        cfg,
  input logic              irq,
  input logic              irq_oe
);

  logic [NREG*W-1:0] clr_bits;
  logic [NREG*W-1:0] keep_bits;

  for (genvar r = 0; r < NREG; r++) begin : g_exp
    assign clr_bits[r*W +: W] = {W{clr_sel[r]}};
  end
  assign keep_bits = (sts & ~clr_bits) | evt;

  // R1: set bits and unread bits persist
  a_r1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts & $past(keep_bits)) == $past(keep_bits)));

  // R2: read clears the addressed register's bits that had no event
  a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts & $past(clr_bits & ~evt)) == '0));

  // R3: event beats a coinciding read
  a_r3_evt_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts & $past(clr_bits & evt)) == $past(clr_bits & evt)));

  // R5: active state follows pending by one edge
  a_r5_follow: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (act == $past(pend)));

  // R6: pin driven whenever active
  a_r6_oe_active: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> irq_oe);

  // R6: idle pin floats when selected
  a_r6_float_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!act && cfg[0]) |-> !irq_oe);

  // R6: active-low code pulls the pin low when active
  a_r6_low_active: assert property (@(posedge clk) disable iff (!rst_n)
    (act && cfg[1]) |-> !irq);

  // R8: out-of-range address selects no register
  a_r8_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && (int'(rd_addr) >= int'(NREG))) |-> (clr_sel == '0));

endmodule

bind irqagg_top irqagg_chk #(.NREG(NREG), .W(W), .AW(AW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .evt     (evt_i),
  .sts     (sts),
  .clr_sel (clr_sel),
  .rd_stb  (rd_stb_i),
  .rd_addr (rd_addr_i),
  .pend    (pend),
  .act     (act),
  .cfg     (pin_cfg_i),
  .irq     (irq_o),
  .irq_oe  (irq_oe_o)
);

// File: tb/tb_irqagg_top.sv
module tb_irqagg_top;

  localparam int W    = 8;
  localparam int NFRM = 8;
  localparam int NREG = NFRM + 3;
  localparam int AW   = $clog2(NREG);
  localparam int NB   = NREG * W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NB-1:0] evt = '0;
  logic [NB-1:0] en  = '0;
  logic [3:0]    blk = '0;
  logic [1:0]    cfg = '0;
  logic          rd_stb = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  wire  [W-1:0]  rd_data;
  wire           irq;
  wire           oe;

  int tests = 0;
  int fails = 0;
  bit mon_on = 1'b0;

  always #2 clk = ~clk;

  irqagg_top #(.W(W), .NFRM(NFRM)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt),
    .bit_en_i  (en),
    .grp_en_i  (blk),
    .pin_cfg_i (cfg),
    .rd_stb_i  (rd_stb),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .irq_o     (irq),
    .irq_oe_o  (oe)
  );

  // ---------------- reference model ----------------
  logic [W-1:0] m_sts [NREG];
  logic         m_act = 1'b0;

  function automatic int tb_grp(int r);
    case (r)
      0:        return 0;
      1:        return 1;
      NREG - 1: return 3;
      default:  return 2;
    endcase
  endfunction

  function automatic bit tb_pending();
    for (int r = 0; r < NREG; r++)
      for (int b = 0; b < W; b++)
        if (m_sts[r][b] && en[r*W+b] && blk[tb_grp(r)]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit exp_oe(logic [1:0] c, bit a);
    if (a) return 1'b1;
    return !c[0];
  endfunction

  function automatic bit exp_lvl(logic [1:0] c, bit a);
    return c[1] ? !a : a;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) m_sts[r] = '0;
      m_act = 1'b0;
    end else begin
      m_act = tb_pending();
      for (int r = 0; r < NREG; r++) begin
        if (rd_stb && int'(rd_addr) == r) m_sts[r] = '0;
        m_sts[r] = m_sts[r] | evt[r*W +: W];
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      chk("R5/R6 irq level", {31'd0, irq}, {31'd0, exp_lvl(cfg, m_act)});
      chk("R6 irq enable",   {31'd0, oe},  {31'd0, exp_oe(cfg, m_act)});
      if (int'(rd_addr) < NREG)
        chk("R2 read data", {24'd0, rd_data}, {24'd0, m_sts[int'(rd_addr)]});
    end
  end

  task automatic step(input int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic fire(input int r, input int b);
    evt[r*W+b] = 1'b1;
    step();
    evt = '0;
  endtask

  task automatic rd(input int a);
    rd_stb = 1'b1; rd_addr = AW'(a);
    step();
    rd_stb = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    step(3);
    @(negedge clk);
    chk("R7 reset level",  {31'd0, irq}, 32'd0);
    chk("R7 reset enable", {31'd0, oe},  32'd1);
    chk("R7 reset status", {24'd0, rd_data}, 32'd0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    mon_on = 1'b1;
    step();

    // R4: framer group disabled masks a framer bit
    en = '1; blk = 4'b1011;
    fire(5, 3);
    step(2);
    @(negedge clk);
    chk("R4 framer masked", {31'd0, irq}, 32'd0);
    @(posedge clk); #1;
    blk = 4'b1111;
    step();
    @(negedge clk);
    chk("R4 framer enabled", {31'd0, irq}, 32'd1);
    @(posedge clk); #1;

    // R2/R5: read, then drop one edge later
    rd_stb = 1'b1; rd_addr = AW'(5);
    @(negedge clk);
    chk("R2 pre-clear data", {24'd0, rd_data}, 32'h08);
    @(posedge clk); #1;
    rd_stb = 1'b0;
    @(negedge clk);
    chk("R2 cleared", {24'd0, rd_data}, 32'd0);
    chk("R5 still active after read edge", {31'd0, irq}, 32'd1);
    @(posedge clk); #1;
    @(negedge clk);
    chk("R5 idle one edge later", {31'd0, irq}, 32'd0);
    @(posedge clk); #1;

    // R3: event together with clearing read
    fire(1, 1);
    evt[1*W+0] = 1'b1; rd_stb = 1'b1; rd_addr = AW'(1);
    step();
    evt = '0; rd_stb = 1'b0;
    @(negedge clk);
    chk("R3 event survives read", {24'd0, rd_data}, 32'h01);
    @(posedge clk); #1;
    @(negedge clk);
    chk("R3 interrupt held", {31'd0, irq}, 32'd1);
    @(posedge clk); #1;

    // R1 + R8: out-of-range reads clear nothing
    fire(NREG - 1, 7);
    rd(13);
    rd(15);
    rd_addr = AW'(NREG - 1);
    @(negedge clk);
    chk("R8 link bit kept", {24'd0, rd_data}, 32'h80);
    @(posedge clk); #1;
    rd_addr = AW'(1);
    @(negedge clk);
    chk("R1 line bit kept", {24'd0, rd_data}, 32'h01);
    @(posedge clk); #1;

    // R9: masking does not erase
    en = '0;
    step(2);
    @(negedge clk);
    chk("R9 masked idle", {31'd0, irq}, 32'd0);
    chk("R9 status kept", {24'd0, rd_data}, 32'h01);
    @(posedge clk); #1;
    en = '1;
    step(2);
    @(negedge clk);
    chk("R9 re-enabled active", {31'd0, irq}, 32'd1);
    @(posedge clk); #1;

    // R6: pin table, active side
    for (int c = 0; c < 4; c++) begin
      cfg = 2'(c);
      @(negedge clk);
      chk("R6 active enable", {31'd0, oe}, 32'd1);
      chk("R6 active level", {31'd0, irq}, (c >= 2) ? 32'd0 : 32'd1);
      @(posedge clk); #1;
    end
    rd(1); rd(NREG - 1);
    step(2);
    // R6: pin table, idle side
    for (int c = 0; c < 4; c++) begin
      cfg = 2'(c);
      @(negedge clk);
      chk("R6 idle enable", {31'd0, oe}, (c % 2 == 1) ? 32'd0 : 32'd1);
      if (c % 2 == 0)
        chk("R6 idle level", {31'd0, irq}, (c >= 2) ? 32'd1 : 32'd0);
      @(posedge clk); #1;
    end

    // random phase, judged by the per-cycle monitor
    for (int i = 0; i < 4000; i++) begin
      for (int r = 0; r < NREG; r++)
        evt[r*W +: W] = ($urandom_range(0, 5) == 0) ? W'($urandom) : '0;
      rd_stb  = ($urandom_range(0, 2) == 0);
      rd_addr = AW'($urandom_range(0, (1 << AW) - 1));
      if (i % 64 == 0) en = {$urandom, $urandom, $urandom}[NB-1:0];
      if (i % 50 == 0) blk = 4'($urandom);
      if (i % 200 == 0) cfg = 2'($urandom);
      step();
    end
    evt = '0; rd_stb = 1'b0;
    step(2);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule